// File: doc/BRIEF.md
# Double-Buffered Down-Counting PWM Channel

One pulse-width-modulation timer channel. A down-counter advances by one on each tick enable, where the tick comes from a separate prescaler. The channel holds a period value and a compare value in two buffer inputs. Those values reach the live counter and comparator only at defined moments. One is a manual-update strobe. The other is the terminal count of a period, and only when auto-reload is on. Software can therefore rewrite the buffers at any time without tearing the waveform in progress.

Control arrives as one shared control word. The word carries a 4-bit field for every channel of a timer bank, and the parameter `CHAN` selects which field this instance decodes. The bank layout is irregular and the channel reproduces it, because its neighbours decode the same word. Channel 0 takes slot 0, slot 1 is unused, and channel k takes slot k+1. The last channel has no invert control and takes its auto-reload enable from bit 2 of its slot.

A period of N ticks is programmed as N−1. The pre-inversion output is asserted while the live count is at or below the live compare value. The invert control is normally set: in that setting the pin is high for N−1−compare ticks of each period, which counts as normal polarity.

Top module: `pwm_dbuf_channel`

## Requirements
- R1: While the manual-update bit of the channel's field is 1, each clock copies `period_buf` into the live counter and `cmp_buf` into the live compare. The counter does not count during those clocks, and the copy clears the stopped state. With start 0 afterwards, the output reflects the newly loaded compare: the pre-inversion level is 1 when period ≤ compare.
- R2: With start 1, manual update 0 and not stopped, the live counter drops by one on each clock with `tick` 1 and a nonzero count. Without `tick`, or with start 0, it holds.
- R3: The live counter runs from the period value down to 0, so a programmed value P gives a period of P+1 ticks. `period_end` is 1 for exactly the one clock after a tick taken at count 0. The smallest supported P is 1.
- R4: With auto-reload 1, a tick at count 0 reloads both buffers into the live registers. Buffer changes made during a period take effect only from the next period.
- R5: With auto-reload 0, a tick at count 0 stops the channel. The pre-inversion output is then 0, and there is no further counting and no `period_end` until the next manual update.
- R6: The pre-inversion output is 1 when the live count ≤ live compare (unsigned). An all-ones compare holds it at 1 for the whole period.
- R7: Invert bit 1 drives `pwm_out` as the complement of the pre-inversion level. The pin is then high for P−compare ticks of each period.
- R8: Field bits are start = bit 0, manual update = bit 1, invert = bit 2, auto-reload = bit 3. The field of channel `CHAN` sits at `ctrl_word[4*s+3:4*s]` with s = 0 for `CHAN` = 0 and s = `CHAN`+1 otherwise. The bits of any other slot, including unused slot 1, have no effect.
- R9: For the last channel (`CHAN` = `NCHAN`−1, slot `NCHAN`), auto-reload is bit 2 of the slot. That channel has no invert, and bit 3 of its slot is ignored.
- R10: After reset the channel is stopped with count 0, `period_end` is 0 and the pre-inversion output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Count enable from the prescaler |
| ctrl_word | input | 4*(NCHAN+1) | Shared bank control word |
| period_buf | input | CNT_W | Buffered period value (ticks minus one) |
| cmp_buf | input | CNT_W | Buffered compare value |
| pwm_out | output | 1 | PWM pin |
| period_end | output | 1 | One-clock pulse after the terminal tick |

## Verification
The live count, live compare and stopped state are all registered on the clock edge that samples their inputs. `pwm_out` is combinational from those registers, so a load, tick or stop shows on the pin in the cycle right after that edge. `period_end` is registered as well and appears in the cycle after the terminal tick edge. The bench drives inputs on the falling edge and samples on later falling edges, so every sample sees the state after exactly one more rising edge. For periodic waveforms the bench counts high samples and pulses over a whole number of periods. Where the reload moment matters, it records the sample index of each pulse.

// File: rtl/pwm_dbuf_channel.sv
module pwm_dbuf_channel #(
  parameter int CNT_W = 16,
  parameter int NCHAN = 5,
  parameter int CHAN  = 0
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   tick,
  input  logic [4*(NCHAN+1)-1:0] ctrl_word,
  input  logic [CNT_W-1:0]       period_buf,
  input  logic [CNT_W-1:0]       cmp_buf,
  output logic                   pwm_out,
  output logic                   period_end
);

  localparam int SLOT    = (CHAN == 0) ? 0 : CHAN + 1;
  localparam int BASE    = 4 * SLOT;
  localparam bit IS_LAST = (SLOT == NCHAN);
  localparam int ARL_BIT = IS_LAST ? 2 : 3;

  logic [CNT_W-1:0] cnt_q, cmp_q;
  logic             stopped_q, pend_q;
  logic             f_start, f_upd, f_inv, f_arl, raw, at_zero, step;

  assign f_start = ctrl_word[BASE + 0];
  assign f_upd   = ctrl_word[BASE + 1];
  assign f_arl   = ctrl_word[BASE + ARL_BIT];

  generate
    if (IS_LAST) begin : g_noinv
      assign f_inv = 1'b0;
    end else begin : g_inv
      assign f_inv = ctrl_word[BASE + 2];
    end
  endgenerate

  assign at_zero = (cnt_q == '0);
  assign step    = !f_upd && f_start && !stopped_q && tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      cmp_q     <= '0;
      stopped_q <= 1'b1;
      pend_q    <= 1'b0;
    end else begin
      pend_q <= step && at_zero;
      if (f_upd) begin
        cnt_q     <= period_buf;
        cmp_q     <= cmp_buf;
        stopped_q <= 1'b0;
      end else if (step) begin
        if (!at_zero) begin
          cnt_q <= cnt_q - 1'b1;
        end else if (f_arl) begin
          cnt_q <= period_buf;
          cmp_q <= cmp_buf;
        end else begin
          stopped_q <= 1'b1;
        end
      end
    end
  end

  assign raw        = !stopped_q && (cnt_q <= cmp_q);
  assign pwm_out    = raw ^ f_inv;
  assign period_end = pend_q;

  // R1
  load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    f_upd |=> (cnt_q == $past(period_buf)) && (cmp_q == $past(cmp_buf)) && !stopped_q);

  // R2
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!f_upd && !tick) |=> $stable(cnt_q) && $stable(cmp_q));

  // R3
  pulse_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    period_end |-> ($past(cnt_q) == '0) && $past(tick));

  // R3
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    period_end |=> !period_end);

  // R5
  stopped_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stopped_q && !f_upd) |=> !period_end && $stable(cnt_q) && !raw);

  // R6
  full_cmp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!stopped_q && (cmp_q == {CNT_W{1'b1}})) |-> raw);

endmodule

// File: tb/test_pwm_dbuf_channel.sv
module test_pwm_dbuf_channel;
  localparam int W = 16;
  localparam int NC = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic [4*(NC+1)-1:0] ctrl = '0;
  logic [W-1:0] pb0 = '0, cb0 = '0, pb4 = '0, cb4 = '0;
  logic out0, pe0, out4, pe4;
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  pwm_dbuf_channel #(.CNT_W(W), .NCHAN(NC), .CHAN(0)) i_pwm_dbuf_channel (
    .clk(clk), .rst_n(rst_n), .tick(tick), .ctrl_word(ctrl),
    .period_buf(pb0), .cmp_buf(cb0), .pwm_out(out0), .period_end(pe0));

  pwm_dbuf_channel #(.CNT_W(W), .NCHAN(NC), .CHAN(4)) i_pwm_dbuf_channel_last (
    .clk(clk), .rst_n(rst_n), .tick(tick), .ctrl_word(ctrl),
    .period_buf(pb4), .cmp_buf(cb4), .pwm_out(out4), .period_end(pe4));

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  // load channel 0 with one manual-update clock, then apply run bits
  task automatic load0(input logic [3:0] run, input logic [W-1:0] p, input logic [W-1:0] c);
    pb0 = p; cb0 = c;
    ctrl[3:0] = (run & 4'b1100) | 4'b0010;
    cyc();
    ctrl[3:0] = run;
  endtask

  task automatic t_reset();
    check("R10 out0", out0, 0);
    check("R10 pe0", pe0, 0);
    check("R10 out4", out4, 0);
  endtask

  task automatic t_waveform();
    int hi = 0, pe = 0;
    tick = 1'b1;
    load0(4'b1101, 16'd4, 16'd2);
    check("R1 loaded level inv", out0, 1);
    for (int i = 0; i < 10; i++) begin
      cyc();
      hi += out0; pe += pe0;
    end
    check("R7 high ticks over two periods", hi, 4);
    check("R3 pulses over two periods", pe, 2);
  endtask

  task automatic t_gating();
    int chg = 0, pe = 0;
    logic ref_o;
    tick = 1'b0;
    cyc();
    ref_o = out0;
    for (int i = 0; i < 6; i++) begin
      cyc();
      chg += (out0 != ref_o); pe += pe0;
    end
    check("R2 no tick output stable", chg, 0);
    check("R2 no tick no pulse", pe, 0);
    tick = 1'b1;
  endtask

  task automatic t_oneshot();
    int hi = 0, pe = 0;
    load0(4'b0001, 16'd2, 16'd0);
    check("R1 loaded level", out0, 0);
    for (int i = 0; i < 8; i++) begin
      cyc();
      hi += out0; pe += pe0;
    end
    check("R5 single pulse", pe, 1);
    check("R6 asserted ticks", hi, 1);
    check("R5 stopped output", out0, 0);
  endtask

  task automatic t_full();
    int hi = 0;
    load0(4'b1001, 16'd3, 16'hFFFF);
    for (int i = 0; i < 8; i++) begin
      cyc();
      hi += out0;
    end
    check("R6 all-ones compare constant", hi, 8);
  endtask

  task automatic t_stopped_level();
    load0(4'b0000, 16'd3, 16'd5);
    cyc();
    check("R1 stopped level from compare 5", out0, 1);
    load0(4'b0000, 16'd3, 16'd1);
    cyc();
    check("R1 stopped level from compare 1", out0, 0);
    ctrl[2] = 1'b1;
    cyc();
    check("R7 invert of stopped level", out0, 1);
    ctrl[2] = 1'b0;
  endtask

  task automatic t_reload();
    int pos[$];
    load0(4'b1001, 16'd4, 16'd0);
    pb0 = 16'd1;
    for (int i = 1; i <= 9; i++) begin
      cyc();
      if (pe0) pos.push_back(i);
    end
    check("R4 pulse count", pos.size(), 3);
    if (pos.size() == 3) begin
      check("R4 old period kept", pos[0], 5);
      check("R4 new period used", pos[1], 7);
      check("R4 new period repeats", pos[2], 9);
    end
  endtask

  task automatic t_layout();
    int pe = 0, hi = 0, chg = 0;
    logic ref_o;
    check("R8 last channel untouched by slot 0", out4, 0);
    ctrl = '0;
    cyc();
    ref_o = out0;
    ctrl[7:4] = 4'hF;
    for (int i = 0; i < 4; i++) begin
      cyc();
      chg += (out0 != ref_o) + out4; pe += pe0 + pe4;
    end
    check("R8 unused slot no effect", chg + pe, 0);
    ctrl[7:4] = 4'h0;
    pb4 = 16'd2; cb4 = 16'd0;
    ctrl[23:20] = 4'b0110;
    cyc();
    ctrl[23:20] = 4'b0101;
    pe = 0;
    for (int i = 0; i < 9; i++) begin
      cyc();
      pe += pe4; hi += out4;
    end
    check("R9 bit2 auto-reload pulses", pe, 3);
    check("R9 no inversion on last channel", hi, 3);
    ctrl[23:20] = 4'b1010;
    cyc();
    ctrl[23:20] = 4'b1001;
    pe = 0;
    for (int i = 0; i < 9; i++) begin
      cyc();
      pe += pe4;
    end
    check("R9 bit3 ignored, one-shot", pe, 1);
    check("R8 channel 0 idle meanwhile", pe0, 0);
  endtask

  initial begin
    fork
      begin
        repeat (3) cyc();
        rst_n = 1'b1;
        cyc();
        t_reset();
        t_waveform();
        t_gating();
        t_oneshot();
        t_full();
        t_stopped_level();
        t_reload();
        t_layout();
      end
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule